// File: doc/BRIEF.md
# Clock User Register Shadow with Event Freeze

This block sits between a free-running time/date counter set and a byte-wide host register port. The counters present eight bytes of live time. On every periodic update strobe the block copies all eight bytes into user-visible shadow registers, and the host reads the shadows rather than the live counters. Because the counters keep moving while a multi-byte read is in progress, the block holds the shadows still for the whole of any host transaction that starts on a clock byte. A strobe that arrives during that window, or while the system runs in backup mode, is kept as a pending copy. The pending copy is applied as soon as the window closes and backup mode ends.

A control byte sits one address above the clock bytes. It can be reached at any time and never opens the freeze window. It holds a halt flag, a tamper-enable flag and a read-only tamper-hold flag. A power-failure pulse sets the halt flag, unless tamper enable is on, so the shadows keep the time of the event. With tamper enable on, a tamper pulse sets the tamper-hold flag instead. In either frozen state the sub-second byte reads 00 and the other seven bytes keep their last copied values. When the host clears the halt flag or the tamper-enable flag, the shadows are reloaded at once from the counters, which never stopped.

Top module: `rtc_user_shadow`

## Requirements
- R1: After reset every shadow byte, the control byte (address 8) and host_rdata are 0.
- R2: An update_tick while the window is closed, backup_mode is low and the block is not frozen loads all eight live_time bytes (byte k = bits 8k+7..8k) into shadow bytes 0..7 at the next clock edge.
- R3: A transaction that starts at an address 0..7 opens a window. The window lasts from the xact_start cycle through the xact_stop cycle, and no copy happens during it. A tick inside the window is held and applied in the cycle after the window closes.
- R4: While backup_mode is high no copy happens. A tick seen during backup is applied once backup_mode falls.
- R5: A power_fail pulse while tamper enable (control bit 1) is 0 sets the halt flag (control bit 0). While frozen, shadow byte 0 reads 00, bytes 1..7 keep their values and ticks are discarded.
- R6: A tamper_evt pulse while control bit 1 is 1 sets the read-only hold flag (control bit 2) and freezes the shadows as in R5. A power_fail pulse while bit 1 is 1 leaves the halt flag clear.
- R7: Writing 0 to the halt flag, or writing 0 to the tamper-enable flag, ends the freeze and clears the hold flag. The shadows then load the current live_time without waiting for a tick.
- R8: The control byte at address 8 is written and read through the host port. Host writes store bit 2 as 0. A transaction at address 8 does not block ticks.
- R9: Each host_rd or host_wr advances the address pointer from 7 to 0 and otherwise by one within 0..7. At address 8 and above the pointer stays put. host_rdata shows the addressed byte in the cycle after host_rd.
- R10: Host writes at addresses 0..7 leave the shadow bytes unchanged.
- R11: Addresses 9..15 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| live_time | input | 64 | Eight live counter bytes, byte 0 lowest |
| update_tick | input | 1 | Periodic copy request |
| backup_mode | input | 1 | System running on backup supply |
| power_fail | input | 1 | Power-failure event pulse |
| tamper_evt | input | 1 | Tamper event pulse |
| xact_start | input | 1 | Host transaction start, loads the pointer |
| xact_addr | input | 4 | Start address of the transaction |
| xact_stop | input | 1 | Host transaction end |
| host_rd | input | 1 | Read the byte at the pointer |
| host_wr | input | 1 | Write host_wdata at the pointer |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid the cycle after host_rd |

## Verification
The bench builds the block with its defaults: eight 8-bit clock bytes, a 4-bit address, immediate reload on resume and registered read data. With these values the 7-to-0 wrap, the lone control byte at 8 and the empty addresses 9 to 15 all fall within one 4-bit address space, so one bench covers them. Because resume reloads at once, R7 can be checked with no tick at all. A check there shows that the halt and tamper paths reload the shadows by themselves.

// File: rtl/rtc_shadow_pkg.sv
package rtc_shadow_pkg;

   typedef enum logic [1:0] {
      SRC_NONE  = 2'd0,
      SRC_CLOCK = 2'd1,
      SRC_CTRL  = 2'd2
   } addr_kind_e;

   // Clock bytes occupy 0..nclk-1, the control byte sits right above them.
   function automatic addr_kind_e kind_of(input int unsigned a, input int unsigned nclk);
      if (a < nclk)       return SRC_CLOCK;
      else if (a == nclk) return SRC_CTRL;
      else                return SRC_NONE;
   endfunction

endpackage

// File: rtl/rtc_shadow_stamp.sv
module rtc_shadow_stamp #(
   parameter int BYTE_W   = 8,
   parameter int HT_BIT   = 0,
   parameter int TEB_BIT  = 1,
   parameter int HOLD_BIT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_we,
   input  logic [BYTE_W-1:0] ctrl_wdata,
   input  logic              power_fail,
   input  logic              tamper_evt,
   output logic [BYTE_W-1:0] ctrl_rd,
   output logic              freeze
);

   logic [BYTE_W-1:0] reg_q;
   logic              hold_q;
   logic              teb_now;

   assign teb_now = reg_q[TEB_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_q <= '0;
      end else begin
         if (ctrl_we) begin
            reg_q           <= ctrl_wdata;
            reg_q[HOLD_BIT] <= 1'b0;
         end
         if (power_fail && !teb_now)
            reg_q[HT_BIT] <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hold_q <= 1'b0;
      else if (tamper_evt && teb_now)
         hold_q <= 1'b1;
      else if (ctrl_we && !ctrl_wdata[TEB_BIT])
         hold_q <= 1'b0;
   end

   always_comb begin
      ctrl_rd           = reg_q;
      ctrl_rd[HOLD_BIT] = hold_q;
   end

   assign freeze = reg_q[HT_BIT] | hold_q;

endmodule

// File: rtl/rtc_shadow_gate.sv
module rtc_shadow_gate #(
   parameter bit RESUME_COPY = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic update_tick,
   input  logic backup_mode,
   input  logic freeze,
   input  logic xact_start,
   input  logic start_is_clock,
   input  logic xact_stop,
   output logic win_now,
   output logic copy_en
);

   logic win_q;
   logic pend_q;
   logic resume_req;
   logic open_now;
   logic want;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         win_q <= 1'b0;
      else if (xact_start)
         win_q <= start_is_clock;
      else if (xact_stop)
         win_q <= 1'b0;
   end

   assign win_now = win_q | (xact_start & start_is_clock);

   generate
      if (RESUME_COPY) begin : g_resume
         logic freeze_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) freeze_q <= 1'b0;
            else        freeze_q <= freeze;
         end
         assign resume_req = freeze_q & ~freeze;
      end else begin : g_wait_tick
         assign resume_req = 1'b0;
      end
   endgenerate

   assign open_now = ~win_now & ~backup_mode & ~freeze;
   assign want     = update_tick | pend_q | resume_req;
   assign copy_en  = open_now & want;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pend_q <= 1'b0;
      else if (freeze)  pend_q <= 1'b0;
      else if (copy_en) pend_q <= 1'b0;
      else              pend_q <= want;
   end

endmodule

// File: rtl/rtc_shadow_bank.sv
module rtc_shadow_bank #(
   parameter int NUM_CLK = 8,
   parameter int BYTE_W  = 8,
   localparam int LIVE_W = NUM_CLK * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              copy_en,
   input  logic              freeze,
   input  logic [LIVE_W-1:0] live_time,
   output logic [LIVE_W-1:0] shadow
);

   generate
      for (genvar g = 0; g < NUM_CLK; g++) begin : g_byte
         if (g == 0) begin : g_subsec
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  shadow[BYTE_W-1:0] <= '0;
               else if (freeze)
                  shadow[BYTE_W-1:0] <= '0;
               else if (copy_en)
                  shadow[BYTE_W-1:0] <= live_time[BYTE_W-1:0];
            end
         end else begin : g_plain
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  shadow[g*BYTE_W +: BYTE_W] <= '0;
               else if (copy_en)
                  shadow[g*BYTE_W +: BYTE_W] <= live_time[g*BYTE_W +: BYTE_W];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/rtc_shadow_port.sv
module rtc_shadow_port
   import rtc_shadow_pkg::*;
#(
   parameter int NUM_CLK   = 8,
   parameter int BYTE_W    = 8,
   parameter int ADDR_W    = 4,
   parameter bit RDATA_REG = 1'b1,
   localparam int LIVE_W   = NUM_CLK * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xact_start,
   input  logic [ADDR_W-1:0] xact_addr,
   input  logic              host_rd,
   input  logic              host_wr,
   input  logic [LIVE_W-1:0] shadow,
   input  logic [BYTE_W-1:0] ctrl_rd,
   output logic              ctrl_we,
   output logic [ADDR_W-1:0] ptr,
   output logic [BYTE_W-1:0] host_rdata
);

   localparam logic [ADDR_W-1:0] LAST_CLK = ADDR_W'(NUM_CLK - 1);

   logic [BYTE_W-1:0] sel;
   addr_kind_e        ptr_kind;

   assign ptr_kind = kind_of(int'(ptr), NUM_CLK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr <= '0;
      else if (xact_start)
         ptr <= xact_addr;
      else if ((host_rd || host_wr) && ptr_kind == SRC_CLOCK)
         ptr <= (ptr == LAST_CLK) ? '0 : ptr + 1'b1;
   end

   always_comb begin
      sel = '0;
      for (int k = 0; k < NUM_CLK; k++)
         if (ptr == ADDR_W'(k)) sel = shadow[k*BYTE_W +: BYTE_W];
      if (ptr_kind == SRC_CTRL) sel = ctrl_rd;
   end

   assign ctrl_we = host_wr & (ptr_kind == SRC_CTRL);

   generate
      if (RDATA_REG) begin : g_rd_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       host_rdata <= '0;
            else if (host_rd) host_rdata <= sel;
         end
      end else begin : g_rd_comb
         assign host_rdata = sel;
      end
   endgenerate

endmodule

// File: rtl/rtc_user_shadow.sv
module rtc_user_shadow
   import rtc_shadow_pkg::*;
#(
   parameter int NUM_CLK     = 8,
   parameter int BYTE_W      = 8,
   parameter int ADDR_W      = 4,
   parameter int HT_BIT      = 0,
   parameter int TEB_BIT     = 1,
   parameter int HOLD_BIT    = 2,
   parameter bit RESUME_COPY = 1'b1,
   parameter bit RDATA_REG   = 1'b1,
   localparam int LIVE_W     = NUM_CLK * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LIVE_W-1:0] live_time,
   input  logic              update_tick,
   input  logic              backup_mode,
   input  logic              power_fail,
   input  logic              tamper_evt,
   input  logic              xact_start,
   input  logic [ADDR_W-1:0] xact_addr,
   input  logic              xact_stop,
   input  logic              host_rd,
   input  logic              host_wr,
   input  logic [BYTE_W-1:0] host_wdata,
   output logic [BYTE_W-1:0] host_rdata
);

   generate
      if (NUM_CLK < 1 || NUM_CLK >= (1 << ADDR_W)) begin : g_bad_depth
         $error("NUM_CLK must leave room for the control byte in the address space");
      end
      if (HT_BIT >= BYTE_W || TEB_BIT >= BYTE_W || HOLD_BIT >= BYTE_W) begin : g_bad_bits
         $error("control flag positions must lie inside the byte");
      end
      if (HT_BIT == TEB_BIT || HT_BIT == HOLD_BIT || TEB_BIT == HOLD_BIT) begin : g_dup_bits
         $error("control flag positions must be distinct");
      end
   endgenerate

   logic              start_is_clock;
   logic              win_now;
   logic              copy_en;
   logic              freeze;
   logic              ctrl_we;
   logic [BYTE_W-1:0] ctrl_rd;
   logic [ADDR_W-1:0] ptr;
   logic [LIVE_W-1:0] shadow;

   assign start_is_clock = (kind_of(int'(xact_addr), NUM_CLK) == SRC_CLOCK);

   rtc_shadow_stamp #(
      .BYTE_W(BYTE_W), .HT_BIT(HT_BIT), .TEB_BIT(TEB_BIT), .HOLD_BIT(HOLD_BIT)
   ) u_stamp (
      .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(host_wdata),
      .power_fail(power_fail), .tamper_evt(tamper_evt),
      .ctrl_rd(ctrl_rd), .freeze(freeze)
   );

   rtc_shadow_gate #(
      .RESUME_COPY(RESUME_COPY)
   ) u_gate (
      .clk(clk), .rst_n(rst_n), .update_tick(update_tick), .backup_mode(backup_mode),
      .freeze(freeze), .xact_start(xact_start), .start_is_clock(start_is_clock),
      .xact_stop(xact_stop), .win_now(win_now), .copy_en(copy_en)
   );

   rtc_shadow_bank #(
      .NUM_CLK(NUM_CLK), .BYTE_W(BYTE_W)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .copy_en(copy_en), .freeze(freeze),
      .live_time(live_time), .shadow(shadow)
   );

   rtc_shadow_port #(
      .NUM_CLK(NUM_CLK), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .RDATA_REG(RDATA_REG)
   ) u_port (
      .clk(clk), .rst_n(rst_n), .xact_start(xact_start), .xact_addr(xact_addr),
      .host_rd(host_rd), .host_wr(host_wr), .shadow(shadow), .ctrl_rd(ctrl_rd),
      .ctrl_we(ctrl_we), .ptr(ptr), .host_rdata(host_rdata)
   );

endmodule

// File: rtl/rtc_shadow_chk.sv
module rtc_shadow_chk #(
   parameter int NUM_CLK  = 8,
   parameter int BYTE_W   = 8,
   parameter int ADDR_W   = 4,
   parameter int HT_BIT   = 0,
   parameter int TEB_BIT  = 1,
   parameter int HOLD_BIT = 2,
   localparam int LIVE_W  = NUM_CLK * BYTE_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [LIVE_W-1:0] live_time,
   input logic              update_tick,
   input logic              backup_mode,
   input logic              power_fail,
   input logic              tamper_evt,
   input logic              xact_start,
   input logic              host_rd,
   input logic              win_now,
   input logic              freeze,
   input logic [ADDR_W-1:0] ptr,
   input logic [LIVE_W-1:0] shadow,
   input logic [BYTE_W-1:0] ctrl_rd
);

   a_r2_tick_copies: assert property (@(posedge clk) disable iff (!rst_n)
      (update_tick && !win_now && !backup_mode && !freeze) |=> shadow == $past(live_time));

   a_r3_window_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (win_now && !freeze) |=> $stable(shadow));

   a_r4_backup_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (backup_mode && !freeze) |=> $stable(shadow));

   a_r5_subsec_zero: assert property (@(posedge clk) disable iff (!rst_n)
      freeze |=> shadow[BYTE_W-1:0] == '0);

   a_r5_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
      freeze |=> $stable(shadow[LIVE_W-1:BYTE_W]));

   a_r5_halt_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (power_fail && !ctrl_rd[TEB_BIT]) |=> ctrl_rd[HT_BIT]);

   a_r6_hold_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (tamper_evt && ctrl_rd[TEB_BIT]) |=> ctrl_rd[HOLD_BIT]);

   a_r9_ptr_wraps: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !xact_start && ptr == ADDR_W'(NUM_CLK - 1)) |=> ptr == '0);

endmodule

bind rtc_user_shadow rtc_shadow_chk #(
   .NUM_CLK(NUM_CLK), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W),
   .HT_BIT(HT_BIT), .TEB_BIT(TEB_BIT), .HOLD_BIT(HOLD_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .live_time(live_time), .update_tick(update_tick),
   .backup_mode(backup_mode), .power_fail(power_fail), .tamper_evt(tamper_evt),
   .xact_start(xact_start), .host_rd(host_rd), .win_now(win_now), .freeze(freeze),
   .ptr(ptr), .shadow(shadow), .ctrl_rd(ctrl_rd)
);

// File: tb/rtc_user_shadow_test.sv
`timescale 1ns/1ps
module rtc_user_shadow_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] live_time = '0;
   logic        update_tick = 0, backup_mode = 0, power_fail = 0, tamper_evt = 0;
   logic        xact_start = 0, xact_stop = 0, host_rd = 0, host_wr = 0;
   logic [3:0]  xact_addr = '0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;

   int total = 0;
   int failed = 0;

   always #2 clk = ~clk;

   rtc_user_shadow uut (
      .clk(clk), .rst_n(rst_n), .live_time(live_time), .update_tick(update_tick),
      .backup_mode(backup_mode), .power_fail(power_fail), .tamper_evt(tamper_evt),
      .xact_start(xact_start), .xact_addr(xact_addr), .xact_stop(xact_stop),
      .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
      .host_rdata(host_rdata)
   );

   localparam logic [63:0] VEC [4] = '{
      64'h2312_0307_2359_5999,
      64'h0001_0101_0000_0001,
      64'h9912_3106_1234_5678,
      64'hA55A_F00F_3CC3_0FF0
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         failed++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic tick();
      update_tick = 1; cyc(); update_tick = 0;
   endtask

   task automatic xstart(input logic [3:0] a);
      xact_start = 1; xact_addr = a; cyc(); xact_start = 0;
   endtask

   task automatic xstop();
      xact_stop = 1; cyc(); xact_stop = 0;
   endtask

   task automatic rd(output logic [7:0] v);
      host_rd = 1; cyc(); host_rd = 0; v = host_rdata;
   endtask

   task automatic wr(input logic [7:0] d);
      host_wr = 1; host_wdata = d; cyc(); host_wr = 0;
   endtask

   task automatic read_all(output logic [63:0] v);
      logic [7:0] b;
      xstart(4'd0);
      for (int k = 0; k < 8; k++) begin
         rd(b);
         v[k*8 +: 8] = b;
      end
      xstop();
      cyc();
   endtask

   task automatic read_ctrl(output logic [7:0] v);
      xstart(4'd8); rd(v); xstop(); cyc();
   endtask

   task automatic write_ctrl(input logic [7:0] d);
      xstart(4'd8); wr(d); xstop(); cyc();
   endtask

   initial begin
      #800000;
      failed++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   end

   initial begin
      logic [63:0] got;
      logic [7:0]  b, b2;

      repeat (3) cyc();
      chk("R1 rdata at reset", {56'd0, host_rdata}, 64'd0);
      rst_n = 1; cyc();
      read_all(got);  chk("R1 shadows at reset", got, 64'd0);
      read_ctrl(b);   chk("R1 control at reset", {56'd0, b}, 64'd0);

      // R2: table walk
      for (int i = 0; i < 4; i++) begin
         live_time = VEC[i];
         tick(); cyc();
         read_all(got);
         chk("R2 tick copy", got, VEC[i]);
      end

      // R9: wrap from 7 to 0, starting mid-bank
      xstart(4'd6);
      rd(b); chk("R9 read at 6", {56'd0, b}, {56'd0, VEC[3][55:48]});
      rd(b); chk("R9 read at 7", {56'd0, b}, {56'd0, VEC[3][63:56]});
      rd(b); chk("R9 wrap to 0", {56'd0, b}, {56'd0, VEC[3][7:0]});
      xstop(); cyc();

      // R3: tick inside window is deferred
      live_time = 64'h1111_2222_3333_4444;
      xstart(4'd0);
      rd(b); chk("R3 byte0 held", {56'd0, b}, {56'd0, VEC[3][7:0]});
      tick();
      rd(b); chk("R3 byte1 held in window", {56'd0, b}, {56'd0, VEC[3][15:8]});
      xstop(); cyc();
      read_all(got); chk("R3 pending applied", got, 64'h1111_2222_3333_4444);

      // R4: backup suspends copying
      backup_mode = 1;
      live_time = 64'h5555_6666_7777_8888;
      tick(); cyc();
      read_all(got); chk("R4 held in backup", got, 64'h1111_2222_3333_4444);
      backup_mode = 0; cyc(); cyc();
      read_all(got); chk("R4 pending after backup", got, 64'h5555_6666_7777_8888);

      // R10: writes to clock bytes do not touch shadows
      xstart(4'd2); wr(8'hFF); wr(8'hEE); xstop(); cyc();
      read_all(got); chk("R10 clock write ignored", got, 64'h5555_6666_7777_8888);

      // R11: empty addresses
      xstart(4'd9); rd(b); wr(8'h55); rd(b2); xstop(); cyc();
      chk("R11 read empty", {56'd0, b}, 64'd0);
      chk("R11 pointer holds at 9", {56'd0, b2}, 64'd0);
      read_ctrl(b);  chk("R11 control untouched", {56'd0, b}, 64'd0);

      // R8: control byte, hold bit not writable, no window
      write_ctrl(8'hAC);
      read_ctrl(b); chk("R8 control write/read", {56'd0, b}, 64'h0000_0000_0000_00A8);
      live_time = 64'h0102_0304_0506_0708;
      xstart(4'd8); tick(); rd(b); rd(b2); xstop(); cyc();
      chk("R9 pointer stays at 8", {56'd0, b2}, {56'd0, b});
      read_all(got); chk("R8 tick copies during control access", got, 64'h0102_0304_0506_0708);

      // R5: power failure freeze
      live_time = 64'h2024_0615_0945_3077;
      tick(); cyc();
      power_fail = 1; cyc(); power_fail = 0; cyc(); cyc();
      live_time = 64'h2024_0615_0946_0012;
      tick(); cyc();
      read_all(got); chk("R5 frozen stamp", got, 64'h2024_0615_0945_3000);
      read_ctrl(b); chk("R5 halt flag set", {56'd0, b}, 64'h0000_0000_0000_00A9);

      // R7: clearing halt reloads without a tick
      write_ctrl(8'hA8); cyc();
      read_all(got); chk("R7 resume after halt", got, 64'h2024_0615_0946_0012);

      // R6: tamper stamp with tamper enable
      write_ctrl(8'h02);
      live_time = 64'h3030_4040_5050_6066;
      tick(); cyc();
      tamper_evt = 1; cyc(); tamper_evt = 0; cyc(); cyc();
      read_ctrl(b); chk("R6 hold flag set", {56'd0, b}, 64'h0000_0000_0000_0006);
      live_time = 64'h3030_4040_5050_7077;
      tick(); cyc();
      read_all(got); chk("R6 tamper stamp", got, 64'h3030_4040_5050_6000);
      power_fail = 1; cyc(); power_fail = 0; cyc();
      read_ctrl(b); chk("R6 power fail ignored with tamper enable", {56'd0, b}, 64'h0000_0000_0000_0006);

      // R7: clearing tamper enable releases the hold
      write_ctrl(8'h00); cyc();
      read_all(got); chk("R7 resume after tamper", got, 64'h3030_4040_5050_7077);
      read_ctrl(b); chk("R7 hold cleared", {56'd0, b}, 64'd0);

      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   end

endmodule